// File: doc/BRIEF.md
# Region-Based Stride Prefetch Engine

This block watches demand load addresses and learns one constant stride per tracked address region. Once a region's stride is confirmed, it issues prefetch line addresses ahead of the demand stream. Each request carries a level flag. The flag is clear for a near-level fill and set for a far-level hint, chosen by how far the request runs ahead of demand.

A small table of region engines trains in three steps. The first access to an unseen region allocates an engine. The second computes a candidate stride in lines. The third confirms it. On confirmation the engine issues a burst up to its target distance. Every later access that keeps the stride tops the run back up. Requests go through a small issue queue that has a valid/ready output. A configuration word sets the following:

- the global enable;
- the initial distance;
- the largest distance that is still marked near-level;
- the largest allowed distance;
- the number of usable queue slots.

An address splits into a region tag in the bits above REGION_BITS, a line index inside the region, and a byte offset inside the 64-byte line. The byte offset is ignored.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, out_valid is 0 and stays 0 until a trained engine issues.
- R2: An engine issues only on the third access to its region, and only if the line difference matches the one from the second access. Training is counted in lines, where a line is address bits [REGION_BITS-1:6]. From confirmed line L with stride d, the engine issues, in order, the line addresses {tag, L+k*d, 6'b0} for k = 1 up to its target distance.
- R3: The target distance is the smaller of cfg_init_dist and cfg_max_dist, both 5-bit fields. No engine ever runs more than that many lines ahead of its last demand.
- R4: A request k strides ahead of the last demand has out_l2 = 1 when k > cfg_max_l1, and out_l2 = 0 otherwise.
- R5: Each further access that matches the stride advances the demand pointer by one stride. The engine then issues one request so that it stays at the target distance.
- R6: An access to a trained engine that breaks the stride produces no request. That access becomes the new previous address, so two more matching accesses are needed before issue resumes.
- R7: A prefetch line that would fall outside the engine's region is never issued. The engine stops at the boundary.
- R8: When no engine matches and every engine is in use, the least recently accessed engine is replaced.
- R9: While cfg_en is 0, all engines return to idle and the queue empties, so out_valid is 0 from the next cycle. After enable returns, a region needs three accesses before it issues again.
- R10: While out_valid is 1 and out_ready is 0, out_addr and out_l2 hold. The queue holds at most cfg_q_depth+1 entries. Requests leave in issue order with none lost under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Global enable; low flushes the engines and the queue |
| cfg_init_dist | input | 5 | Distance used for the burst that follows confirmation |
| cfg_max_l1 | input | 5 | Largest lead still marked near-level |
| cfg_max_dist | input | 5 | Largest lead allowed |
| cfg_q_depth | input | $clog2(Q_DEPTH) | Usable queue slots minus one |
| dem_valid | input | 1 | Demand access strobe |
| dem_addr | input | ADDR_W | Demand byte address |
| out_valid | output | 1 | Prefetch request available |
| out_ready | input | 1 | Consumer accepts the request |
| out_addr | output | ADDR_W | Line-aligned prefetch address |
| out_l2 | output | 1 | 1 = far-level hint, 0 = near-level fill |

## Verification
The bench uses the defaults: 2 engines, 4 KiB regions of 64 lines, and a 4-slot queue.

Two engines mean a third region forces an eviction, so the least-recently-used victim can be told apart from the most recently used one. With only 64 lines per region, a short run from a start near the top hits the boundary.

A sweep covers positive and negative strides, several initial distances and several near-level limits. For each combination it predicts every burst and top-up address and its level arithmetically. Directed cases cover the following:
- distance clamping;
- a broken stride;
- the enable flush;
- a two-slot queue held stalled.

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 12,
  parameter int N_ENG       = 2,
  parameter int Q_DEPTH     = 4,
  localparam int LINE_BITS  = 6,
  localparam int LW         = REGION_BITS - LINE_BITS,
  localparam int TW         = ADDR_W - REGION_BITS,
  localparam int IW         = (N_ENG > 1) ? $clog2(N_ENG) : 1,
  localparam int QW         = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [4:0]        cfg_init_dist,
  input  logic [4:0]        cfg_max_l1,
  input  logic [4:0]        cfg_max_dist,
  input  logic [QW-1:0]     cfg_q_depth,
  input  logic              dem_valid,
  input  logic [ADDR_W-1:0] dem_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_l2
);
  typedef enum logic [1:0] {E_IDLE, E_ONE, E_TWO, E_RUN} eng_st_t;

  eng_st_t           st     [N_ENG];
  logic [TW-1:0]     tag    [N_ENG];
  logic [LW-1:0]     prev   [N_ENG];
  logic signed [LW:0] stride[N_ENG];
  logic [LW-1:0]     tail   [N_ENG];
  logic [4:0]        ahead  [N_ENG];
  logic [4:0]        tgt    [N_ENG];
  logic [IW-1:0]     age    [N_ENG];
  logic [LW+1:0]     nxt    [N_ENG];

  logic [TW-1:0]     q_tag  [Q_DEPTH];
  logic [LW-1:0]     q_line [Q_DEPTH];
  logic              q_l2   [Q_DEPTH];
  logic [QW-1:0]     q_rd, q_wr;
  logic [QW:0]       q_cnt;

  logic [TW-1:0] dem_tag;
  logic [LW-1:0] dem_line;
  assign dem_tag  = dem_addr[ADDR_W-1:REGION_BITS];
  assign dem_line = dem_addr[REGION_BITS-1:LINE_BITS];

  logic          any_hit, any_free, any_ok;
  logic [IW-1:0] hit_idx, free_idx, lru_idx, sel;
  always_comb begin
    any_hit = 1'b0; any_free = 1'b0; any_ok = 1'b0;
    hit_idx = '0; free_idx = '0; lru_idx = '0; sel = '0;
    for (int i = N_ENG - 1; i >= 0; i--) begin
      nxt[i] = {2'b00, tail[i]} + {stride[i][LW], stride[i]};
      if (st[i] != E_IDLE && tag[i] == dem_tag) begin any_hit = 1'b1; hit_idx = IW'(i); end
      if (st[i] == E_IDLE) begin any_free = 1'b1; free_idx = IW'(i); end
      if (age[i] == IW'(N_ENG - 1)) lru_idx = IW'(i);
      if (st[i] == E_RUN && ahead[i] < tgt[i] && nxt[i][LW+1:LW] == 2'b00) begin
        any_ok = 1'b1; sel = IW'(i);
      end
    end
  end

  logic [IW-1:0]      touch;
  logic signed [LW:0] diff;
  logic [4:0]         tgt_new;
  logic               push, pop;
  assign touch   = any_hit ? hit_idx : (any_free ? free_idx : lru_idx);
  assign diff    = $signed({1'b0, dem_line}) - $signed({1'b0, prev[hit_idx]});
  assign tgt_new = (cfg_init_dist < cfg_max_dist) ? cfg_init_dist : cfg_max_dist;
  assign push    = cfg_en && !dem_valid && any_ok && (q_cnt <= {1'b0, cfg_q_depth});
  assign out_valid = (q_cnt != '0);
  assign out_addr  = {q_tag[q_rd], q_line[q_rd], {LINE_BITS{1'b0}}};
  assign out_l2    = q_l2[q_rd];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_en) begin
      q_rd <= '0; q_wr <= '0; q_cnt <= '0;
      for (int i = 0; i < N_ENG; i++) begin
        st[i] <= E_IDLE;
        if (!rst_n) begin
          tag[i] <= '0; prev[i] <= '0; stride[i] <= '0; tail[i] <= '0;
          ahead[i] <= '0; tgt[i] <= '0; age[i] <= IW'(i);
        end
      end
      if (!rst_n)
        for (int j = 0; j < Q_DEPTH; j++) begin q_tag[j] <= '0; q_line[j] <= '0; q_l2[j] <= 1'b0; end
    end else begin
      if (push) begin
        q_tag[q_wr]  <= tag[sel];
        q_line[q_wr] <= nxt[sel][LW-1:0];
        q_l2[q_wr]   <= ({1'b0, ahead[sel]} + 6'd1) > {1'b0, cfg_max_l1};
        q_wr         <= (q_wr == QW'(Q_DEPTH - 1)) ? '0 : q_wr + 1'b1;
        tail[sel]    <= nxt[sel][LW-1:0];
        ahead[sel]   <= ahead[sel] + 5'd1;
      end
      if (pop) q_rd <= (q_rd == QW'(Q_DEPTH - 1)) ? '0 : q_rd + 1'b1;
      q_cnt <= q_cnt + (QW+1)'(push) - (QW+1)'(pop);
      if (dem_valid) begin
        for (int i = 0; i < N_ENG; i++)
          if (IW'(i) == touch) age[i] <= '0;
          else if (age[i] < age[touch]) age[i] <= age[i] + 1'b1;
        if (!any_hit) begin
          st[touch] <= E_ONE; tag[touch] <= dem_tag; prev[touch] <= dem_line;
        end else begin
          case (st[hit_idx])
            E_ONE: if (diff != 0) begin
              stride[hit_idx] <= diff; prev[hit_idx] <= dem_line; st[hit_idx] <= E_TWO;
            end
            E_TWO: if (diff == stride[hit_idx]) begin
              st[hit_idx] <= E_RUN; prev[hit_idx] <= dem_line; tail[hit_idx] <= dem_line;
              ahead[hit_idx] <= '0; tgt[hit_idx] <= tgt_new;
            end else if (diff != 0) begin
              stride[hit_idx] <= diff; prev[hit_idx] <= dem_line;
            end
            E_RUN: if (diff == stride[hit_idx]) begin
              prev[hit_idx] <= dem_line;
              if (ahead[hit_idx] == '0) tail[hit_idx] <= dem_line;
              else ahead[hit_idx] <= ahead[hit_idx] - 5'd1;
            end else begin
              st[hit_idx] <= E_ONE; prev[hit_idx] <= dem_line;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/prefetch_chk.sv
module prefetch_chk #(
  parameter int ADDR_W = 32,
  parameter int QW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [QW-1:0]     cfg_q_depth,
  input logic              dem_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_l2,
  input logic [QW:0]       q_cnt
);
  logic [1:0] seen;
  always_ff @(posedge clk)
    if (!rst_n || !cfg_en) seen <= '0;
    else if (dem_valid && seen != 2'd3) seen <= seen + 2'd1;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n || !cfg_en)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_l2)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !out_valid);

  assert_trained_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen == 2'd3));

  assert_q_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt > $past(q_cnt)) |-> ($past(q_cnt) <= {1'b0, $past(cfg_q_depth)} && q_cnt == $past(q_cnt) + 1'b1));
endmodule

bind stride_prefetcher prefetch_chk #(.ADDR_W(ADDR_W), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_q_depth(cfg_q_depth),
  .dem_valid(dem_valid), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_l2(out_l2), .q_cnt(q_cnt)
);

// File: tb/test_stride_prefetcher.sv
`timescale 1ns/1ps
module test_stride_prefetcher;
  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, dem_valid = 0, out_ready = 1;
  logic [4:0] cfg_init_dist = 0, cfg_max_l1 = 0, cfg_max_dist = 31;
  logic [1:0] cfg_q_depth = 2'd3;
  logic [31:0] dem_addr = 0;
  logic out_valid, out_l2;
  logic [31:0] out_addr;

  stride_prefetcher i_stride_prefetcher (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] rec_a [64]; logic rec_l [64]; int rec_n = 0;
  logic [31:0] exp_a [64]; logic exp_l [64]; int exp_n = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n && out_valid && out_ready && rec_n < 64) begin
      rec_a[rec_n] = out_addr; rec_l[rec_n] = out_l2; rec_n++;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    summary();
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic dem(input logic [19:0] rg, input int line);
    @(posedge clk); #2;
    dem_valid = 1; dem_addr = {rg, line[5:0], 6'h18};
    @(posedge clk); #2;
    dem_valid = 0;
  endtask

  task automatic clr();
    rec_n = 0; exp_n = 0;
  endtask

  task automatic expect_run(input logic [19:0] rg, input int base, input int d,
                            input int k0, input int k1, input int ml1);
    for (int k = k0; k <= k1; k++) begin
      int ln = base + k * d;
      if (ln < 0 || ln > 63) break;
      exp_a[exp_n] = {rg, ln[5:0], 6'h00}; exp_l[exp_n] = (k > ml1); exp_n++;
    end
  endtask

  task automatic compare(input string rq);
    check({rq, " count"}, 64'(rec_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      check({rq, " addr"}, 64'(rec_a[i]), 64'(exp_a[i]));
      check({rq, " level"}, 64'(rec_l[i]), 64'(exp_l[i]));
    end
  endtask

  task automatic flush();
    @(posedge clk); #2; cfg_en = 0;
    idle(2); cfg_en = 1; idle(1);
  endtask

  initial begin
    int strides [5] = '{1, 2, -1, -3, 5};
    int inits [3] = '{0, 3, 8};
    int ml1s [3] = '{0, 2, 31};
    int idx = 0;
    idle(4);
    check("R1 reset valid", 64'(out_valid), 64'd0);
    rst_n = 1; idle(2);
    check("R1 idle valid", 64'(out_valid), 64'd0);
    cfg_en = 1; idle(2);

    foreach (strides[s]) foreach (inits[a]) foreach (ml1s[m]) begin
      int d = strides[s]; int st = (d > 0) ? 4 : 60; int l3 = st + 2 * d;
      logic [19:0] rg = 20'h01000 + 20'(idx);
      idx++;
      cfg_init_dist = 5'(inits[a]); cfg_max_l1 = 5'(ml1s[m]); cfg_max_dist = 31;
      clr(); dem(rg, st); idle(8); dem(rg, st + d); idle(8);
      compare("R2 no issue before confirm");
      clr(); dem(rg, l3); idle(40);
      expect_run(rg, l3, d, 1, inits[a], ml1s[m]);
      compare("R2 R4 burst");
      clr(); dem(rg, l3 + d); idle(20);
      expect_run(rg, l3 + d, d, inits[a], inits[a], ml1s[m]);
      if (inits[a] == 0) exp_n = 0;
      compare("R5 top-up");
    end

    flush();
    cfg_init_dist = 20; cfg_max_dist = 5; cfg_max_l1 = 2;
    clr(); dem(20'h2000, 4); dem(20'h2000, 5); dem(20'h2000, 6); idle(40);
    expect_run(20'h2000, 6, 1, 1, 5, 2);
    compare("R3 clamp");

    cfg_max_dist = 31; cfg_init_dist = 8; cfg_max_l1 = 31;
    clr(); dem(20'h2001, 50); dem(20'h2001, 54); dem(20'h2001, 58); idle(40);
    expect_run(20'h2001, 58, 4, 1, 8, 31);
    compare("R7 boundary");
    clr(); dem(20'h2001, 62); idle(20);
    compare("R7 boundary top-up");

    cfg_init_dist = 3;
    clr(); dem(20'h2002, 4); dem(20'h2002, 6); dem(20'h2002, 8); idle(30);
    clr(); dem(20'h2002, 20); idle(10); dem(20'h2002, 23); idle(10);
    compare("R6 broken stride quiet");
    clr(); dem(20'h2002, 26); idle(30);
    expect_run(20'h2002, 26, 3, 1, 3, 31);
    compare("R6 retrained");

    flush();
    clr();
    dem(20'h3000, 4); dem(20'h3001, 10); dem(20'h3000, 6);
    dem(20'h3002, 30); dem(20'h3000, 8); idle(30);
    expect_run(20'h3000, 8, 2, 1, 3, 31);
    compare("R8 LRU victim");
    clr(); dem(20'h3001, 11); dem(20'h3001, 12); idle(20);
    compare("R8 evicted region retrains");

    flush();
    out_ready = 0; cfg_q_depth = 2'd1; cfg_init_dist = 8; cfg_max_l1 = 3;
    clr(); dem(20'h4000, 10); dem(20'h4000, 12); dem(20'h4000, 14); idle(10);
    check("R10 stalled valid", 64'(out_valid), 64'd1);
    check("R10 stalled head", 64'(out_addr), 64'({20'h4000, 6'd16, 6'h00}));
    idle(10);
    check("R10 stalled hold", 64'(out_addr), 64'({20'h4000, 6'd16, 6'h00}));
    out_ready = 1; idle(40);
    expect_run(20'h4000, 14, 2, 1, 8, 3);
    compare("R10 drain order");

    out_ready = 0; cfg_q_depth = 2'd3;
    clr(); dem(20'h4001, 1); dem(20'h4001, 2); dem(20'h4001, 3); idle(10);
    check("R9 queue filled", 64'(out_valid), 64'd1);
    cfg_en = 0; idle(1);
    check("R9 flush valid", 64'(out_valid), 64'd0);
    idle(2);
    check("R9 off valid", 64'(out_valid), 64'd0);
    cfg_en = 1; out_ready = 1; idle(1);
    clr(); dem(20'h4001, 4); idle(20);
    compare("R9 engines cleared");
    dem(20'h4001, 5); dem(20'h4001, 6); idle(30);
    expect_run(20'h4001, 6, 1, 1, 8, 3);
    compare("R9 retrain after flush");

    summary();
  end
endmodule